// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a 52-bit physical address by walking a four-level radix tree of page tables with 4 KB pages. A translation request carries the virtual address, the kind of access (read, write or instruction fetch) and whether the requester runs in user or supervisor mode. The walker starts from the physical page number of the top-level table, supplied by a root register input. At each level it reads one 64-bit table entry from memory. The 36-bit virtual page number is cut into four 9-bit indices, one per level, so each table has 512 entries.

Every entry the walk reads is checked for presence and permission. A missing entry ends the walk with an absent fault, and a permission breach ends it with a permission fault. When the leaf entry passes, the walker sets its accessed flag, and also its dirty flag on a write. It writes the entry back to memory only when one of those flags actually changes, and reports the result only after that write has completed. The physical address is the leaf's 40-bit frame number joined to the untouched 12-bit page offset.

Only one translation is in flight at a time. The memory side is a plain request/acknowledge port: the walker holds a request steady until the memory acknowledges it.

Top module: `pt_walker`

## Requirements
- R1: In the first cycle after synchronous reset is released, `req_ready` is 1 and both `res_valid` and `mem_req` are 0.
- R2: The entry read at each level is at address {table frame (40 bits), 9-bit index, 3'b000}. The first table frame is `root_ppn` and each later one is bits 51:12 of the entry just read. The indices come from virtual address bits 47:39, 38:30, 29:21 and 20:12, in that order.
- R3: A walk that passes all four levels returns `res_fault`=0, `res_cause`=0 and `res_paddr` = {leaf bits 51:12, `req_vaddr`[11:0]}.
- R4: An entry whose bit 0 is 0 ends the walk at that level with `res_fault`=1, `res_cause`=1 and `res_paddr`=0. No further entry is read and nothing is written, whatever the entry's other bits hold.
- R5: Permission is checked at every level. A write (`req_acc`=1) needs bit 1 set. A user request needs bit 2 set. A fetch (`req_acc`=2) needs bit 63 clear. Code 0 and code 3 are both plain reads, and a supervisor read passes any present entry. A breach ends the walk at that level with `res_fault`=1, `res_cause`=2 and `res_paddr`=0, and nothing is written.
- R6: A successful walk sets bit 5 of the leaf entry, and a write also sets bit 6. The updated entry is written (`mem_we`=1) to the leaf's own address only when its value changes. A faulted walk never writes.
- R7: `res_valid` is a one-cycle pulse, raised on the clock edge that takes the last `mem_ack` of the walk.
- R8: `req_ready` falls on the edge that accepts a request and stays 0 until the result is reported.
- R9: While `mem_req` is 1 and not yet acknowledged, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| req_user | input | 1 | 1 for a user-mode request, 0 for supervisor |
| root_ppn | input | 40 | Frame number of the top-level table |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write of `mem_wdata`, 0 for a read |
| mem_addr | output | 52 | Byte address of the 64-bit entry |
| mem_wdata | output | 64 | Entry value to write |
| mem_ack | input | 1 | One-cycle acknowledge, carries read data |
| mem_rdata | input | 64 | Entry read from memory, valid with `mem_ack` |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Walk ended in a fault |
| res_cause | output | 2 | 0 none, 1 absent entry, 2 permission breach |
| res_paddr | output | 52 | Translated physical address, 0 on fault |

## Verification
The bench's memory model raises `mem_ack` L+1 cycles after it first sees a request, and the walker takes the acknowledge on the next edge, so each memory access costs L+2 cycles. The result therefore arrives exactly (reads + write-backs) × (L+2) cycles after the request is accepted. The bench works out the number of reads and write-backs from its own walk of the table image, counts edges from acceptance, and compares the count at the falling edge where `res_valid` is first seen. It samples `req_ready` at every falling edge in between, and it compares the recorded entry addresses, the write count and the updated table word once the result is out, with L varied from walk to walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTE_W  = 64;
  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;
  localparam int BIT_XD = 63;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    CS_NONE   = 2'd0,
    CS_ABSENT = 2'd1,
    CS_PERM   = 2'd2
  } cause_e;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_READ  = 2'd1,
    W_WBACK = 2'd2
  } wstate_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PPN_W  = 40,
  parameter int VPN_W  = 36,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  parameter int ENT_SH = 3,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int PA_W  = PPN_W + IDX_W + ENT_SH
) (
  input  logic [PPN_W-1:0] base,
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  addr
);
  // one index slice per level, top level takes the most significant bits
  logic [IDX_W-1:0] slice [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_slice
    assign slice[l] = vpn[VPN_W-1-l*IDX_W -: IDX_W];
  end

  always_comb begin
    addr = {base, slice[level], {ENT_SH{1'b0}}};
  end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic present,
  input  logic writable,
  input  logic user_ok,
  input  logic no_exec,
  input  acc_e acc,
  input  logic user,
  output logic absent,
  output logic denied
);
  logic wr_bad, us_bad, ex_bad;

  always_comb begin
    wr_bad = (acc == ACC_WRITE) && !writable;
    us_bad = user && !user_ok;
    ex_bad = (acc == ACC_FETCH) && no_exec;
    absent = !present;
    denied = present && (wr_bad || us_bad || ex_bad);
  end
endmodule

// File: rtl/ptw_ad_update.sv
module ptw_ad_update
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] entry,
  input  logic             is_write,
  output logic [PTE_W-1:0] updated,
  output logic             changed
);
  always_comb begin
    updated        = entry;
    updated[BIT_A] = 1'b1;
    if (is_write) updated[BIT_D] = 1'b1;
    changed = (updated != entry);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 52,
  parameter int PAGE_SH = 12,
  parameter int IDX_W   = 9,
  parameter int LEVELS  = 4,
  localparam int PPN_W  = PA_W - PAGE_SH,
  localparam int VPN_W  = VA_W - PAGE_SH,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int ENT_SH = $clog2(PTE_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  input  logic [PPN_W-1:0]  root_ppn,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [PTE_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [PTE_W-1:0]  mem_rdata,
  output logic              res_valid,
  output logic              res_fault,
  output logic [1:0]        res_cause,
  output logic [PA_W-1:0]   res_paddr
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  wstate_e           state;
  logic [LVL_W-1:0]  level;
  logic [VA_W-1:0]   va_q;
  acc_e              acc_q;
  logic              user_q;
  logic [PPN_W-1:0]  leaf_ppn;

  // next entry address: root table on acceptance, otherwise the table just read
  logic [PPN_W-1:0]  gen_base;
  logic [VPN_W-1:0]  gen_vpn;
  logic [LVL_W-1:0]  gen_level;
  logic [PA_W-1:0]   gen_addr;

  always_comb begin
    if (state == W_IDLE) begin
      gen_base  = root_ppn;
      gen_vpn   = req_vaddr[VA_W-1:PAGE_SH];
      gen_level = '0;
    end else begin
      gen_base  = mem_rdata[PA_W-1:PAGE_SH];
      gen_vpn   = va_q[VA_W-1:PAGE_SH];
      gen_level = LVL_W'(level + 1'b1);
    end
  end

  ptw_addr_gen #(
    .PPN_W (PPN_W),
    .VPN_W (VPN_W),
    .IDX_W (IDX_W),
    .LEVELS(LEVELS),
    .ENT_SH(ENT_SH)
  ) u_addr (
    .base (gen_base),
    .vpn  (gen_vpn),
    .level(gen_level),
    .addr (gen_addr)
  );

  logic absent, denied;

  ptw_perm_check u_perm (
    .present (mem_rdata[BIT_P]),
    .writable(mem_rdata[BIT_RW]),
    .user_ok (mem_rdata[BIT_US]),
    .no_exec (mem_rdata[BIT_XD]),
    .acc     (acc_q),
    .user    (user_q),
    .absent  (absent),
    .denied  (denied)
  );

  logic [PTE_W-1:0] upd_entry;
  logic             upd_changed;

  ptw_ad_update u_ad (
    .entry   (mem_rdata),
    .is_write(acc_q == ACC_WRITE),
    .updated (upd_entry),
    .changed (upd_changed)
  );

  assign req_ready = (state == W_IDLE);

  always_ff @(posedge clk) begin
    res_valid <= 1'b0;
    if (rst) begin
      state     <= W_IDLE;
      level     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      res_fault <= 1'b0;
      res_cause <= CS_NONE;
      res_paddr <= '0;
    end else begin
      case (state)
        W_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            acc_q    <= acc_e'(req_acc);
            user_q   <= req_user;
            level    <= '0;
            mem_addr <= gen_addr;
            mem_we   <= 1'b0;
            mem_req  <= 1'b1;
            state    <= W_READ;
          end
        end
        W_READ: begin
          if (mem_ack) begin
            if (absent || denied) begin
              mem_req   <= 1'b0;
              state     <= W_IDLE;
              res_valid <= 1'b1;
              res_fault <= 1'b1;
              res_cause <= absent ? CS_ABSENT : CS_PERM;
              res_paddr <= '0;
            end else if (level == LAST_LVL) begin
              leaf_ppn <= mem_rdata[PA_W-1:PAGE_SH];
              if (upd_changed) begin
                mem_we    <= 1'b1;
                mem_wdata <= upd_entry;
                state     <= W_WBACK;
              end else begin
                mem_req   <= 1'b0;
                state     <= W_IDLE;
                res_valid <= 1'b1;
                res_fault <= 1'b0;
                res_cause <= CS_NONE;
                res_paddr <= {mem_rdata[PA_W-1:PAGE_SH], va_q[PAGE_SH-1:0]};
              end
            end else begin
              level    <= LVL_W'(level + 1'b1);
              mem_addr <= gen_addr;
            end
          end
        end
        W_WBACK: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            state     <= W_IDLE;
            res_valid <= 1'b1;
            res_fault <= 1'b0;
            res_cause <= CS_NONE;
            res_paddr <= {leaf_ppn, va_q[PAGE_SH-1:0]};
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !mem_req && !res_valid));

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && mem_req));

  // R7
  res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R7
  res_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(mem_ack));

  // R6
  wb_sets_access_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[BIT_A]);

  // R6
  fault_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault) |-> !$past(mem_req && mem_we));

  // R4
  fault_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault) |-> (res_cause != 2'd0 && res_paddr == '0));

  // R3
  ok_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_fault) |-> (res_cause == 2'd0));
endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  localparam int NTAB  = 8;
  localparam int WORDS = NTAB * 512;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [47:0] req_vaddr;
  logic [1:0]  req_acc;
  logic        req_user;
  logic [39:0] root_ppn;
  logic        mem_req, mem_we;
  logic [51:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack;
  logic [63:0] mem_rdata;
  logic        res_valid, res_fault;
  logic [1:0]  res_cause;
  logic [51:0] res_paddr;

  always #2 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_user(req_user), .root_ppn(root_ppn),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_fault(res_fault), .res_cause(res_cause), .res_paddr(res_paddr)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [63:0] pmem [WORDS];
  int          mem_lat = 0;
  int          cnt = 0;
  int          obs_n = 0;
  int          wr_n = 0;
  logic [51:0] obs_addr [16];
  logic [51:0] start_addr;
  bit          hold_err = 0;

  function automatic int slot_of(input logic [51:0] a);
    logic [39:0] p;
    p = a[51:12];
    if (p >= 40'd1 && p <= 40'(NTAB)) return int'(p - 40'd1) * 512 + int'(a[11:3]);
    return -1;
  endfunction

  function automatic logic [63:0] rd_word(input logic [51:0] a);
    int s;
    s = slot_of(a);
    if (s >= 0) return pmem[s];
    return 64'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      cnt     <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (cnt == 0) start_addr <= mem_addr;
      if (cnt != 0 && mem_addr != start_addr) hold_err <= 1'b1;
      if (cnt >= mem_lat) begin
        cnt     <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          wr_n <= wr_n + 1;
          if (slot_of(mem_addr) >= 0) pmem[slot_of(mem_addr)] <= mem_wdata;
        end else begin
          mem_rdata <= rd_word(mem_addr);
          obs_addr[obs_n % 16] <= mem_addr;
          obs_n <= obs_n + 1;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  // ---------------- reference walk ----------------
  bit          exp_fault;
  logic [1:0]  exp_cause;
  logic [51:0] exp_pa;
  int          exp_nrd;
  logic [51:0] exp_ra [4];
  bit          exp_wb;
  int          exp_wslot;
  logic [63:0] exp_wval;

  task automatic ref_walk(input logic [47:0] va, input logic [1:0] acc, input bit user);
    logic [39:0] b;
    logic [63:0] e, n;
    logic [51:0] a;
    b = root_ppn;
    exp_fault = 0; exp_cause = 0; exp_pa = '0; exp_nrd = 0; exp_wb = 0;
    exp_wslot = -1; exp_wval = '0;
    for (int l = 0; l < 4; l++) begin
      a = {b, va[47-9*l -: 9], 3'b000};
      exp_ra[l] = a;
      e = rd_word(a);
      exp_nrd++;
      if (!e[0]) begin exp_fault = 1; exp_cause = 2'd1; return; end
      if ((acc == 2'd1 && !e[1]) || (user && !e[2]) || (acc == 2'd2 && e[63])) begin
        exp_fault = 1; exp_cause = 2'd2; return;
      end
      if (l == 3) begin
        n = e | 64'h20 | ((acc == 2'd1) ? 64'h40 : 64'h0);
        exp_pa = {e[51:12], va[11:0]};
        if (n != e) begin exp_wb = 1; exp_wslot = slot_of(a); exp_wval = n; end
      end
      b = e[51:12];
    end
  endtask

  function automatic logic [63:0] mkpte(input logic [39:0] base, input bit p,
                                        input bit rw, input bit us, input bit xd);
    logic [63:0] e;
    e = '0;
    e[51:12] = base;
    e[0] = p; e[1] = rw; e[2] = us; e[63] = xd;
    return e;
  endfunction

  function automatic int ts(input int t, input int i);
    return (t - 1) * 512 + i;
  endfunction

  // ---------------- one translation ----------------
  bit          last_fault;
  logic [1:0]  last_cause;
  logic [51:0] last_pa;

  task automatic do_walk(input logic [47:0] va, input logic [1:0] acc,
                         input bit user, input int lat);
    int    obs0, wr0, cyc, nacc;
    bit    rdy_bad, hung;
    string tg;
    ref_walk(va, acc, user);
    @(negedge clk);
    mem_lat   = lat;
    hold_err  = 0;
    obs0      = obs_n;
    wr0       = wr_n;
    req_vaddr = va;
    req_acc   = acc;
    req_user  = user;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    cyc = 0; rdy_bad = 0; hung = 0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      if (res_valid) break;
      if (req_ready) rdy_bad = 1;
      if (cyc > 2000) begin hung = 1; break; end
      @(posedge clk);
      cyc++;
    end
    last_fault = res_fault; last_cause = res_cause; last_pa = res_paddr;
    tg = (exp_cause == 2'd0) ? "R3" : ((exp_cause == 2'd1) ? "R4" : "R5");
    chk(!hung, "R7", "result arrived", 64'(hung), 64'd0);
    chk(res_fault == exp_fault && res_cause == exp_cause, tg, "fault/cause",
        {res_fault, res_cause}, {exp_fault, exp_cause});
    chk(res_paddr == exp_pa, tg, "paddr", 64'(res_paddr), 64'(exp_pa));
    begin
      bit ok_ra;
      ok_ra = (obs_n - obs0) == exp_nrd;
      for (int k = 0; k < exp_nrd && k < 4; k++)
        if (obs_addr[(obs0 + k) % 16] != exp_ra[k]) ok_ra = 0;
      chk(ok_ra, "R2", "entry read sequence", 64'(obs_n - obs0), 64'(exp_nrd));
    end
    chk((wr_n - wr0) == int'(exp_wb), "R6", "write-back count", 64'(wr_n - wr0), 64'(exp_wb));
    if (exp_wb)
      chk(pmem[exp_wslot] == exp_wval, "R6", "updated entry", pmem[exp_wslot], exp_wval);
    nacc = exp_nrd + int'(exp_wb);
    chk(cyc == nacc * (lat + 2), "R7", "latency", 64'(cyc), 64'(nacc * (lat + 2)));
    chk(!rdy_bad, "R8", "ready low while busy", 64'(rdy_bad), 64'd0);
    chk(!hold_err, "R9", "address held until ack", 64'(hold_err), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] dva;
    void'($urandom(32'd7321));
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_user = 1'b0;
    root_ppn = 40'd1;
    for (int i = 0; i < WORDS; i++) pmem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !res_valid && !mem_req, "R1", "idle after reset",
        {res_valid, mem_req, req_ready}, 64'b001);

    // directed chain: table1[1] -> t2, t2[2] -> t3, t3[3] -> t4, t4[4] leaf
    dva = {9'd1, 9'd2, 9'd3, 9'd4, 12'h5A5};
    pmem[ts(1,1)] = mkpte(40'd2, 1, 1, 1, 0);
    pmem[ts(2,2)] = mkpte(40'd3, 1, 1, 1, 0);
    pmem[ts(3,3)] = mkpte(40'd4, 1, 1, 1, 0);
    pmem[ts(4,4)] = mkpte(40'hABCDE12345, 1, 1, 1, 0);

    do_walk(dva, 2'd0, 1'b1, 1);
    chk(!last_fault && last_pa == {40'hABCDE12345, 12'h5A5}, "R3", "directed paddr",
        64'(last_pa), 64'({40'hABCDE12345, 12'h5A5}));
    chk(pmem[ts(4,4)][5] && !pmem[ts(4,4)][6], "R6", "read sets accessed only",
        pmem[ts(4,4)], mkpte(40'hABCDE12345, 1, 1, 1, 0) | 64'h20);
    do_walk(dva, 2'd0, 1'b1, 0);
    do_walk(dva, 2'd1, 1'b0, 2);
    chk(pmem[ts(4,4)][6] == 1'b1, "R6", "write sets dirty", pmem[ts(4,4)], 64'h40);
    do_walk(dva, 2'd1, 1'b0, 3);
    do_walk(dva, 2'd2, 1'b1, 1);
    do_walk(dva, 2'd3, 1'b1, 0);

    pmem[ts(2,2)][63] = 1'b1;
    do_walk(dva, 2'd2, 1'b0, 1);
    chk(last_fault && last_cause == 2'd2, "R5", "fetch through no-exec table",
        {last_fault, last_cause}, 64'b110);
    do_walk(dva, 2'd0, 1'b0, 1);
    pmem[ts(2,2)][63] = 1'b0;

    pmem[ts(4,4)][2] = 1'b0;
    do_walk(dva, 2'd0, 1'b1, 2);
    chk(last_fault && last_cause == 2'd2, "R5", "user on supervisor page",
        {last_fault, last_cause}, 64'b110);
    do_walk(dva, 2'd0, 1'b0, 2);
    chk(!last_fault, "R5", "supervisor read of supervisor page", 64'(last_fault), 64'd0);
    pmem[ts(4,4)][2] = 1'b1;

    pmem[ts(1,1)][1] = 1'b0;
    do_walk(dva, 2'd1, 1'b0, 1);
    chk(last_fault && last_cause == 2'd2, "R5", "write through read-only top table",
        {last_fault, last_cause}, 64'b110);
    pmem[ts(1,1)][1] = 1'b1;

    pmem[ts(3,3)] = 64'hFFFF_FFFF_FFFF_FFFE;
    do_walk(dva, 2'd1, 1'b1, 1);
    chk(last_fault && last_cause == 2'd1 && last_pa == '0, "R4", "absent with junk bits",
        {last_fault, last_cause}, 64'b101);

    // random table image
    for (int i = 0; i < WORDS; i++) begin
      logic [63:0] e;
      logic [39:0] b;
      e = {$urandom, $urandom};
      b = (($urandom % 16) == 0) ? 40'({$urandom, $urandom}) : 40'(1 + ($urandom % NTAB));
      e[51:12] = b;
      e[0]  = ($urandom % 8) != 0;
      e[1]  = ($urandom % 4) != 0;
      e[2]  = ($urandom % 4) != 0;
      e[63] = ($urandom % 8) == 0;
      pmem[i] = e;
    end
    for (int n = 0; n < 300; n++) begin
      logic [47:0] rva;
      rva = 48'({$urandom, $urandom});
      root_ppn = 40'(1 + ($urandom % NTAB));
      do_walk(rva, 2'($urandom % 4), 1'($urandom % 2), int'($urandom % 4));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule